// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is a single down-counting timer channel that produces a pulse-width-modulated level and an underflow interrupt pulse. Software loads a count buffer and a compare buffer through a simple write port. These buffers never drive the output directly. Their contents move into the active counter and compare registers in only two ways: by a manual-update strobe held in the control slice, or by an automatic reload when the counter underflows. This lets software change the period or duty cycle at any moment without tearing the waveform that is currently running.

The channel owns one 4-bit slice of a control word that is shared with sibling channels. The slice holds start, manual-update, output-invert and auto-reload bits. The counter advances only on cycles where the external `tick` enable is high, so the timebase is generated elsewhere. To stop the channel, software writes manual-update and auto-reload with start cleared; this leaves the channel preloaded. To start it, software sets start and clears manual-update in a single write. Without auto-reload the channel runs as a one-shot and halts after its first underflow.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pwm_out` and `irq` are low, and the channel is stopped with all buffers and active registers at zero.
- R2: Writes select a register by `wr_addr`: 0 is the control word, 1 is the count buffer, 2 is the compare buffer, and 3 writes nothing. The channel uses only control bits [4*CH_IDX+3 : 4*CH_IDX], where the slice's bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. A write to address 3, or to control bits outside this slice, changes nothing in this channel.
- R3: While the manual-update bit is set, the count buffer and compare buffer are copied into the active registers on every clock edge, whatever the start bit holds. During this time the counter does not count, `pwm_out` is low and `irq` stays low.
- R4: The channel is running when start is 1, manual update is 0 and the channel is not halted. While running, the active counter decreases by one at each clock edge where `tick` is high. When not running, or when `tick` is low, the counter keeps its value.
- R5: An edge where the channel is running, `tick` is high and the counter is zero is an underflow. `irq` is then high for the following cycle only. If auto-reload is set, the counter and compare registers are reloaded from their buffers, so the period is count buffer + 1 ticks.
- R6: While running, `pwm_out` is high when counter ≤ compare and low otherwise, and the invert bit reverses this. A compare value of at least the count value therefore gives 100 % duty, and a compare value of 0 gives one high tick per period.
- R7: An underflow while auto-reload is clear halts the channel. The counter stops and `pwm_out` is low regardless of the invert bit, and this lasts until a manual update clears the halt.
- R8: Writing a buffer while the channel runs does not change the active values. A new compare value takes effect only at the next auto-reload underflow or manual update.
- R9: With start clear, `pwm_out` and `irq` stay low. When the start write follows the stop sequence (manual update and auto-reload set) and `tick` is high every cycle, `irq` first goes high in the cycle that follows the (count buffer + 1)-th rising edge after the edge that accepts the start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count buffer, 2 compare buffer, 3 unused |
| wr_data | input | max(CNT_W, 4*NUM_CH) | Write data |
| tick | input | 1 | Count enable from the external timebase |
| pwm_out | output | 1 | PWM level |
| irq | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The bench builds the channel with CNT_W=8, NUM_CH=4, CH_IDX=1 and REG_OUT=0. The 8-bit counter keeps periods short, so each duty measurement covers several whole periods. Because the window always spans whole periods, the measured count of high cycles and interrupts does not depend on phase. Setting CH_IDX to 1 puts the channel's slice at a nonzero offset, so writes that set every bit of the three other slices can be shown to have no effect. With REG_OUT=0 the output follows the active registers with no added stage, which lets the restart-latency check land on an exact cycle.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    // Width of one channel's slice in the shared control word
    localparam int SLICE_W    = 4;
    localparam int REG_ADDR_W = 2;

    // Slice layout, most significant bit first
    typedef struct packed {
        logic reload;   // bit 3: auto-reload at underflow
        logic invert;   // bit 2: output polarity
        logic manual;   // bit 1: manual update of active registers
        logic start;    // bit 0: run
    } ctrl_t;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CMP   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int data_width(input int cnt_w, input int num_ch);
        return max_int(cnt_w, num_ch * SLICE_W);
    endfunction

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int CH_IDX = 0,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output ctrl_t                 ctrl,
    output logic [CNT_W-1:0]      cnt_buf,
    output logic [CNT_W-1:0]      cmp_buf
);

    localparam int SLICE_LO = CH_IDX * SLICE_W;

    reg_sel_e sel;
    ctrl_t    ctrl_q;
    logic [CNT_W-1:0] cnt_buf_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic unused_wr_bits;

    assign sel            = reg_sel_e'(wr_addr);
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            cnt_buf_q <= '0;
            cmp_buf_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CTRL:  ctrl_q    <= ctrl_t'(wr_data[SLICE_LO +: SLICE_W]);
                SEL_COUNT: cnt_buf_q <= wr_data[CNT_W-1:0];
                SEL_CMP:   cmp_buf_q <= wr_data[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    assign ctrl    = ctrl_q;
    assign cnt_buf = cnt_buf_q;
    assign cmp_buf = cmp_buf_q;

endmodule

// File: rtl/pwm_dbuf_core.sv
module pwm_dbuf_core
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             run,
    output logic             halted,
    output logic             irq
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             halted_q;
    logic             irq_q;
    logic             step;
    logic             underflow;

    assign run       = ctrl.start & ~ctrl.manual & ~halted_q;
    assign step      = run & tick;
    assign underflow = step & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            cmp_q    <= '0;
            halted_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= underflow;
            if (ctrl.manual) begin
                // manual update wins over counting and clears a halt
                cnt_q    <= cnt_buf;
                cmp_q    <= cmp_buf;
                halted_q <= 1'b0;
            end else if (underflow) begin
                if (ctrl.reload) begin
                    cnt_q <= cnt_buf;
                    cmp_q <= cmp_buf;
                end else begin
                    halted_q <= 1'b1;
                end
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_act = cnt_q;
    assign cmp_act = cmp_q;
    assign halted  = halted_q;
    assign irq     = irq_q;

endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
    parameter int CNT_W   = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt_act,
    input  logic [CNT_W-1:0] cmp_act,
    output logic             pwm_out
);

    logic level;

    // a stopped, halted or updating channel drives low, invert or not
    assign level = run & ((cnt_act <= cmp_act) ^ invert);

    generate
        if (REG_OUT) begin : g_reg
            logic pwm_q;
            always_ff @(posedge clk) begin
                if (rst) pwm_q <= 1'b0;
                else     pwm_q <= level;
            end
            assign pwm_out = pwm_q;
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign pwm_out        = level;
        end
    endgenerate

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 4,
    parameter int CH_IDX  = 0,
    parameter bit REG_OUT = 1'b0,
    localparam int DATA_W = data_width(CNT_W, NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  tick,
    output logic                  pwm_out,
    output logic                  irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_buf;
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cnt_act;
    logic [CNT_W-1:0] cmp_act;
    logic             run_w;
    logic             halted_w;

    pwm_dbuf_regs #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .CH_IDX (CH_IDX),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl_q),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf)
    );

    pwm_dbuf_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl_q),
        .tick    (tick),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf),
        .cnt_act (cnt_act),
        .cmp_act (cmp_act),
        .run     (run_w),
        .halted  (halted_w),
        .irq     (irq)
    );

    pwm_dbuf_out #(
        .CNT_W   (CNT_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .run     (run_w),
        .invert  (ctrl_q.invert),
        .cnt_act (cnt_act),
        .cmp_act (cmp_act),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             irq,
    input logic             pwm_out,
    input logic             man_q,
    input logic             run,
    input logic             halted,
    input logic [CNT_W-1:0] cnt_q
);

    // R5
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick));

    // R3
    manual_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        man_q |=> !irq);

    // R4
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!man_q && !tick) |=> $stable(cnt_q));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R7
    halted_low_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> !pwm_out);

endmodule

bind pwm_dbuf_timer pwm_dbuf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .irq     (irq),
    .pwm_out (pwm_out),
    .man_q   (ctrl_q.manual),
    .run     (run_w),
    .halted  (halted_w),
    .cnt_q   (cnt_act)
);

// File: tb/pwm_dbuf_timer_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_bench;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 4;
    localparam int CH_IDX = 1;
    localparam int DW     = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          tick = 1'b0;
    logic          pwm_out;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    pwm_dbuf_timer #(
        .CNT_W   (CNT_W),
        .NUM_CH  (NUM_CH),
        .CH_IDX  (CH_IDX),
        .REG_OUT (1'b0)
    ) u_pwm_dbuf_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    // periodic tick, one cycle high every tick_div cycles
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick     = 1'b1;
            tick_cnt = 0;
        end else begin
            tick     = 1'b0;
            tick_cnt = tick_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // control word with this channel's slice at bits [7:4]
    function automatic logic [DW-1:0] cw(input bit st, input bit man,
                                         input bit inv, input bit rl);
        return {8'h00, rl, inv, man, st, 4'h0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int c, input int p, input bit inv, input bit rl, input int div);
        tick_div = div;
        wr(2'd1, DW'(c));
        wr(2'd2, DW'(p));
        wr(2'd0, cw(0, 1, inv, rl));
        wr(2'd0, cw(1, 0, inv, rl));
    endtask

    task automatic measure(input int n, output int highs, output int irqs);
        highs = 0;
        irqs  = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            highs += int'(pwm_out);
            irqs  += int'(irq);
        end
    endtask

    task automatic test_reset();
        int h, q;
        @(negedge clk);
        check("R1 pwm in reset", int'(pwm_out), 0);
        check("R1 irq in reset", int'(irq), 0);
        rst = 1'b0;
        measure(1, h, q);
        check("R1 pwm after reset", h, 0);
        check("R1 irq after reset", q, 0);
    endtask

    task automatic test_basic();
        int h, q;
        setup(9, 3, 0, 1, 1);
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R6 duty 4/10", h, 16);
        check("R5 irq per period", q, 4);
    endtask

    task automatic test_invert();
        int h, q;
        setup(9, 3, 1, 1, 1);
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R6 inverted duty", h, 24);
        check("R5 irq inverted", q, 4);
    endtask

    task automatic test_full_and_zero();
        int h, q;
        setup(9, 12, 0, 1, 1);
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R6 full duty", h, 40);
        check("R5 irq full duty", q, 4);
        setup(9, 0, 0, 1, 1);
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R6 compare zero one tick", h, 4);
    endtask

    task automatic test_tick_gate();
        int h, q;
        setup(4, 1, 0, 1, 3);
        repeat (20) @(negedge clk);
        measure(60, h, q);
        check("R4 gated duty", h, 24);
        check("R4 gated irq", q, 4);
        tick_div = 1;
    endtask

    task automatic test_buffer_reload();
        int h, q;
        setup(9, 3, 0, 1, 1);
        repeat (5) @(negedge clk);
        wr(2'd2, DW'(7));
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R8 new compare after reload", h, 32);
    endtask

    task automatic test_oneshot();
        int h, q;
        setup(5, 2, 1, 0, 1);
        measure(40, h, q);
        check("R7 single irq", q, 1);
        measure(20, h, q);
        check("R7 halted low", h, 0);
        check("R7 no more irq", q, 0);
    endtask

    task automatic test_manual_hold();
        int h, q;
        setup(9, 12, 0, 1, 1);
        wr(2'd0, cw(1, 1, 0, 1));
        measure(30, h, q);
        check("R3 manual holds pwm", h, 0);
        check("R3 manual no irq", q, 0);
        wr(2'd0, cw(0, 0, 0, 1));
        measure(30, h, q);
        check("R9 stopped pwm", h, 0);
        check("R9 stopped irq", q, 0);
    endtask

    task automatic test_slices();
        int h, q;
        setup(9, 3, 0, 1, 1);
        wr(2'd0, 16'hFF9F);
        repeat (12) @(negedge clk);
        measure(40, h, q);
        check("R2 foreign slices ignored", h, 16);
        wr(2'd3, 16'h0000);
        measure(40, h, q);
        check("R2 address 3 ignored", h, 16);
        check("R2 address 3 irq", q, 4);
    endtask

    task automatic test_restart();
        int n;
        int h, q;
        tick_div = 1;
        wr(2'd1, DW'(9));
        wr(2'd2, DW'(3));
        wr(2'd0, cw(0, 1, 0, 1));
        measure(10, h, q);
        check("R9 stop sequence low", h + q, 0);
        wr(2'd0, cw(1, 0, 0, 1));
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
        check("R9 restart latency", n, 10);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        test_basic();
        test_invert();
        test_full_and_zero();
        test_tick_gate();
        test_buffer_reload();
        test_oneshot();
        test_manual_hold();
        test_slices();
        test_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule